// File: doc/BRIEF.md
# Enhanced Parallel Port host cycle controller

This block turns host register accesses into Enhanced Parallel Port (EPP) transfers on an 8-bit peripheral bus. One host offset starts address transfers. Three further offsets all start data transfers, and those three behave identically. Every access that hits one of these offsets while EPP mode is enabled runs a single interlocked cycle. The controller drives the direction line and the bus, waits for the peripheral's ready line to go low, and asserts the address or data strobe. It then waits for the acknowledge, which is the ready line going high, and releases the strobe.

The host strobes are level signals sampled on the block clock. Only the rising edge of a host strobe starts a transfer. While the transfer runs, the block raises a busy output and the host keeps its strobe asserted. When the host write strobe falls, the byte on the write data bus at that moment is held on the peripheral bus. For a read, the peripheral bus is sampled when the strobe is released, and that byte is returned to the host until the host drops its read strobe. If the peripheral never responds, a clock counter ends the transfer.

Top module: `epp_host_ctrl`

## Requirements
- R1: After reset both peripheral strobes and the direction line are high (inactive), bus enable is 0, the peripheral output byte is 0x00, host read data is 0x00 and busy is low.
- R2: A host write to offset 3 runs an address-write transfer. The direction line is low and the bus enable is 1 while busy. Only the address strobe pulses, and the written byte appears on the bus non-inverted.
- R3: A host write to offset 4, 5 or 6 runs a data-write transfer in the same way, using only the data strobe.
- R4: A host read of offset 3 runs an address-read transfer with the direction line high and the bus enable 0. The byte present when the address strobe is released is returned on the host read data. It stays unchanged until the host drops its read strobe, even if the bus changes.
- R5: A host read of offset 4, 5 or 6 runs a data-read transfer in the same way, sampled when the data strobe is released.
- R6: A strobe is asserted only on a clock edge at which the ready input was low. In normal operation it is released on the edge after the ready input is seen high. Busy is high whenever a strobe is low.
- R7: While a write transfer is busy, the bus follows the host write data as long as the host write strobe is high. After the strobe falls, the bus holds the last byte until the transfer ends.
- R8: If the peripheral does not respond, busy stays high for exactly TMO_CYC clocks (16 by default), both strobes end high, and the block accepts a new access afterwards.
- R9: With EPP mode disabled, an access to offsets 3 to 6 starts no transfer. No strobe pulses, the bus byte is unchanged and read data is 0x00.
- R10: Accesses to offsets 0, 1, 2 and 7 start no transfer and read back 0x00.
- R11: A host strobe held high starts exactly one transfer. Another starts only after the strobe has fallen and risen again.
- R12: The address and data strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| epp_mode | input | 1 | EPP register set enabled |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, active high, level |
| host_rd | input | 1 | Host read strobe, active high, level |
| host_rdata | output | 8 | Host read data |
| host_busy | output | 1 | Transfer in progress; host holds its strobe |
| pd_out | output | 8 | Peripheral bus output byte |
| pd_in | input | 8 | Peripheral bus input byte |
| pd_oe | output | 1 | Peripheral bus output enable |
| n_write | output | 1 | Direction line, low for writes |
| n_addrstb | output | 1 | Address strobe, active low |
| n_datastb | output | 1 | Data strobe, active low |
| n_wait | input | 1 | Peripheral ready/acknowledge, low = ready |

## Verification
The assertions check on every cycle that the strobes are mutually exclusive and that a strobe falls only after the ready line was low. They also check that no strobe is low without busy, that returned read data never appears during a transfer, that no transfer starts while EPP mode is off, and that busy never lasts longer than the timeout. Some behaviour only the bench scenarios can show. These are the byte values carried in each direction, and the aliasing of the three data offsets. They also include the hold of the trailing-edge write byte and of the read byte, the exact timeout length, and a single transfer per strobe edge.

// File: rtl/epp_pkg.sv
// Shared types and offset constants for the EPP host cycle controller.
// Assumes a 3-bit host offset; offsets are compared after a cast.
package epp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } epp_state_t;

    localparam int OFS_ADDR    = 3;
    localparam int OFS_DATA_LO = 4;
    localparam int OFS_DATA_HI = 6;

endpackage

// File: rtl/epp_host_decode.sv
// Host strobe edge detection and offset decode.
// Produces a one-cycle start pulse on the rising edge of a host strobe
// that hits an EPP offset while EPP mode is enabled. Write wins if both rise.
module epp_host_decode #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          epp_mode,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    output logic          start,
    output logic          start_wr,
    output logic          start_addr
);
    import epp_pkg::*;

    logic wr_q, rd_q;
    logic hit_addr, hit_data;

    // Remember last host strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= host_wr;
            rd_q <= host_rd;
        end
    end

    // Offset decode: one address offset, a contiguous range of data offsets.
    always_comb begin
        hit_addr = (host_addr == AW'(OFS_ADDR));
        hit_data = (host_addr >= AW'(OFS_DATA_LO)) && (host_addr <= AW'(OFS_DATA_HI));
    end

    // Start pulse on a leading edge of either strobe.
    always_comb begin
        start_wr   = host_wr && !wr_q;
        start      = epp_mode && (hit_addr || hit_data) &&
                     ((host_wr && !wr_q) || (host_rd && !rd_q));
        start_addr = hit_addr;
    end

endmodule

// File: rtl/epp_cycle_fsm.sv
// Interlocked EPP cycle sequencer with a no-response timeout.
// SETUP waits for ready low, STROBE waits for acknowledge high, HOLD waits
// for the host to drop its strobe. The timeout ends SETUP/STROBE after
// TMO_CYC clocks in total.
module epp_cycle_fsm #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_wr,
    input  logic start_addr,
    input  logic n_wait,
    input  logic host_wr,
    input  logic host_rd,
    output logic busy,
    output logic in_strobe,
    output logic in_hold,
    output logic cyc_wr,
    output logic cyc_addr,
    output logic capture
);
    import epp_pkg::*;

    localparam int CW = $clog2(TMO_CYC + 1);

    epp_state_t     state;
    logic [CW-1:0]  tmo_cnt;
    logic           tmo_hit;
    logic           host_hold;

    // Timeout and host-release conditions.
    always_comb begin
        tmo_hit   = (tmo_cnt == CW'(TMO_CYC - 1));
        host_hold = cyc_wr ? host_wr : host_rd;
    end

    // State register, cycle kind and timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tmo_cnt  <= '0;
            cyc_wr   <= 1'b0;
            cyc_addr <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_SETUP;
                    tmo_cnt  <= '0;
                    cyc_wr   <= start_wr;
                    cyc_addr <= start_addr;
                end
                ST_SETUP: begin
                    if (tmo_hit)      state <= ST_HOLD;
                    else if (!n_wait) state <= ST_STROBE;
                    tmo_cnt <= tmo_cnt + 1'b1;
                end
                ST_STROBE: begin
                    if (tmo_hit || n_wait) state <= ST_HOLD;
                    tmo_cnt <= tmo_cnt + 1'b1;
                end
                default: if (!host_hold) state <= ST_IDLE;
            endcase
        end
    end

    // Decoded state flags and the read-capture pulse on leaving the active phase.
    always_comb begin
        busy      = (state == ST_SETUP) || (state == ST_STROBE);
        in_strobe = (state == ST_STROBE);
        in_hold   = (state == ST_HOLD);
        capture   = !cyc_wr && ((state == ST_STROBE && (n_wait || tmo_hit)) ||
                                (state == ST_SETUP && tmo_hit));
    end

endmodule

// File: rtl/epp_data_path.sv
// Write-byte latch and read-byte capture.
// The write byte follows host data while the host write strobe is high
// during a write transfer and is frozen when it falls. The read byte is
// captured from the peripheral bus at strobe release.
module epp_data_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic          busy,
    input  logic          in_hold,
    input  logic          cyc_wr,
    input  logic          capture,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] pd_in,
    output logic [DW-1:0] pd_out,
    output logic [DW-1:0] host_rdata
);
    logic [DW-1:0] wr_byte, rd_byte;

    // Write byte: load at write start, track while strobe high, freeze after.
    always_ff @(posedge clk) begin
        if (!rst_n)                           wr_byte <= '0;
        else if (start && start_wr)           wr_byte <= host_wdata;
        else if (busy && cyc_wr && host_wr)   wr_byte <= host_wdata;
    end

    // Read byte: sampled from the peripheral bus when the strobe is released.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_byte <= '0;
        else if (capture) rd_byte <= pd_in;
    end

    // Read data is presented only after a read transfer, until host release.
    always_comb begin
        pd_out     = wr_byte;
        host_rdata = (in_hold && !cyc_wr) ? rd_byte : '0;
    end

endmodule

// File: rtl/epp_host_ctrl.sv
// EPP host cycle controller top level.
// Connects decode, sequencer and data path; derives the peripheral control
// lines from the sequencer state. Host strobes are assumed synchronous to clk.
module epp_host_ctrl #(
    parameter int AW      = 3,
    parameter int DW      = 8,
    parameter int TMO_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          epp_mode,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_wr,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    output logic          host_busy,
    output logic [DW-1:0] pd_out,
    input  logic [DW-1:0] pd_in,
    output logic          pd_oe,
    output logic          n_write,
    output logic          n_addrstb,
    output logic          n_datastb,
    input  logic          n_wait
);
    logic start, start_wr, start_addr;
    logic busy, in_strobe, in_hold, cyc_wr, cyc_addr, capture;

    epp_host_decode #(.AW(AW)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .epp_mode   (epp_mode),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .start      (start),
        .start_wr   (start_wr),
        .start_addr (start_addr)
    );

    epp_cycle_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_wr   (start_wr),
        .start_addr (start_addr),
        .n_wait     (n_wait),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .busy       (busy),
        .in_strobe  (in_strobe),
        .in_hold    (in_hold),
        .cyc_wr     (cyc_wr),
        .cyc_addr   (cyc_addr),
        .capture    (capture)
    );

    epp_data_path #(.DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_wr   (start_wr),
        .busy       (busy),
        .in_hold    (in_hold),
        .cyc_wr     (cyc_wr),
        .capture    (capture),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .pd_in      (pd_in),
        .pd_out     (pd_out),
        .host_rdata (host_rdata)
    );

    // Peripheral control lines from sequencer state.
    always_comb begin
        host_busy = busy;
        pd_oe     = busy && cyc_wr;
        n_write   = !(busy && cyc_wr);
        n_addrstb = !(in_strobe && cyc_addr);
        n_datastb = !(in_strobe && !cyc_addr);
    end

endmodule

// File: rtl/epp_host_ctrl_chk.sv
// Protocol checker for epp_host_ctrl, attached by bind.
// Checks strobe exclusivity, ready interlock, busy coverage, read-data
// timing, mode gating and the timeout bound.
module epp_host_ctrl_chk #(
    parameter int DW      = 8,
    parameter int TMO_CYC = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          epp_mode,
    input logic          host_busy,
    input logic [DW-1:0] host_rdata,
    input logic          n_addrstb,
    input logic          n_datastb,
    input logic          n_wait
);
    localparam int RW = $clog2(TMO_CYC + 2) + 1;
    logic [RW-1:0] busy_run;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_run <= '0;
        else if (host_busy) busy_run <= busy_run + 1'b1;
        else                busy_run <= '0;
    end

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!n_addrstb && !n_datastb));

    assert_addr_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(n_addrstb) |-> $past(!n_wait));

    assert_data_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(n_datastb) |-> $past(!n_wait));

    assert_strobe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!n_addrstb || !n_datastb) |-> host_busy);

    assert_rdata_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> (host_rdata == '0));

    assert_mode_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_busy && !epp_mode) |=> !host_busy);

    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RW'(TMO_CYC));

endmodule

bind epp_host_ctrl epp_host_ctrl_chk #(.DW(DW), .TMO_CYC(TMO_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .epp_mode   (epp_mode),
    .host_busy  (host_busy),
    .host_rdata (host_rdata),
    .n_addrstb  (n_addrstb),
    .n_datastb  (n_datastb),
    .n_wait     (n_wait)
);

// File: tb/sim_epp_host_ctrl.sv
`timescale 1ns/1ps
module sim_epp_host_ctrl;
    localparam int TMO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       epp_mode = 1'b1;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata, pd_out, pd_in;
    logic       host_busy, pd_oe, n_write, n_addrstb, n_datastb;
    logic       n_wait = 1'b0;

    // peripheral model state
    logic       mute = 1'b0;
    logic [7:0] rd_addr_val = '0, rd_data_val = '0;
    logic [7:0] cap_addr = '0, cap_data = '0;
    logic       cap_nwrite = 1'b1, cap_oe = 1'b0;
    int         n_astb = 0, n_dstb = 0;
    logic       prev_a = 1'b1, prev_d = 1'b1;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    assign pd_in = n_addrstb ? rd_data_val : rd_addr_val;

    epp_host_ctrl #(.TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_busy(host_busy), .pd_out(pd_out),
        .pd_in(pd_in), .pd_oe(pd_oe), .n_write(n_write), .n_addrstb(n_addrstb),
        .n_datastb(n_datastb), .n_wait(n_wait)
    );

    // Peripheral: acknowledge strobes, record strobe falls and bus contents.
    always @(negedge clk) begin
        if (!mute) n_wait <= (!n_addrstb || !n_datastb);
        if (prev_a && !n_addrstb) begin
            n_astb <= n_astb + 1; cap_addr <= pd_out; cap_nwrite <= n_write; cap_oe <= pd_oe;
        end
        if (prev_d && !n_datastb) begin
            n_dstb <= n_dstb + 1; cap_data <= pd_out; cap_nwrite <= n_write; cap_oe <= pd_oe;
        end
        prev_a <= n_addrstb;
        prev_d <= n_datastb;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host access; returns read data at completion and after a bus change.
    task automatic access(input logic wr, input logic [2:0] a, input logic [7:0] d,
                          output logic [7:0] rv, output logic [7:0] rv_held);
        @(negedge clk);
        host_addr = a; host_wdata = d;
        if (wr) host_wr = 1'b1; else host_rd = 1'b1;
        @(negedge clk);
        for (int g = 0; g < 100 && host_busy; g++) @(negedge clk);
        @(negedge clk);
        rv = host_rdata;
        rd_addr_val = ~rd_addr_val; rd_data_val = ~rd_data_val;
        @(negedge clk);
        rv_held = host_rdata;
        host_wr = 1'b0; host_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // {ignored, write, offset[2:0], data[7:0], expected[7:0]}
    localparam int NV = 12;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b1, 3'd3, 8'h5A, 8'h5A},
        {1'b0, 1'b1, 3'd4, 8'h11, 8'h11},
        {1'b0, 1'b1, 3'd5, 8'h22, 8'h22},
        {1'b0, 1'b1, 3'd6, 8'hC3, 8'hC3},
        {1'b0, 1'b0, 3'd3, 8'h3C, 8'h3C},
        {1'b0, 1'b0, 3'd4, 8'h81, 8'h7E},
        {1'b0, 1'b0, 3'd5, 8'h00, 8'hFF},
        {1'b0, 1'b0, 3'd6, 8'hF0, 8'h0F},
        {1'b1, 1'b1, 3'd0, 8'h99, 8'h00},
        {1'b1, 1'b1, 3'd2, 8'h98, 8'h00},
        {1'b1, 1'b0, 3'd7, 8'h97, 8'h00},
        {1'b1, 1'b0, 3'd1, 8'h96, 8'h00}
    };

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rv, rh;
        int ca, cd, bcnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 strobes", {n_addrstb, n_datastb, n_write}, 3'b111);
        check("R1 bus", {pd_oe, pd_out}, 9'h000);
        check("R1 host", {host_busy, host_rdata}, 9'h000);

        for (int i = 0; i < NV; i++) begin
            logic ign, wr; logic [2:0] a; logic [7:0] d, e;
            {ign, wr, a, d, e} = VEC[i];
            rd_addr_val = d; rd_data_val = ~d;
            ca = n_astb; cd = n_dstb;
            access(wr, a, d, rv, rh);
            if (ign) begin
                check("R10 no strobe", n_astb + n_dstb, ca + cd);
                check("R10 read zero", rv, 8'h00);
            end else if (wr && a == 3'd3) begin
                check("R2 one addr strobe", {n_astb - ca, n_dstb - cd}, {32'd1, 32'd0});
                check("R2 byte", cap_addr, e);
                check("R2 dir/oe", {cap_nwrite, cap_oe}, 2'b01);
            end else if (wr) begin
                check("R3 one data strobe", {n_astb - ca, n_dstb - cd}, {32'd0, 32'd1});
                check("R3 byte", cap_data, e);
                check("R3 dir/oe", {cap_nwrite, cap_oe}, 2'b01);
            end else if (a == 3'd3) begin
                check("R4 one addr strobe", {n_astb - ca, n_dstb - cd}, {32'd1, 32'd0});
                check("R4 read byte", rv, e);
                check("R4 held byte", rh, e);
                check("R4 dir/oe", {cap_nwrite, cap_oe}, 2'b10);
            end else begin
                check("R5 one data strobe", {n_astb - ca, n_dstb - cd}, {32'd0, 32'd1});
                check("R5 read byte", rv, e);
                check("R5 held byte", rh, e);
            end
            // R11: strobe held through completion produced exactly one transfer
            if (!ign) check("R11 single transfer", (n_astb - ca) + (n_dstb - cd), 1);
        end

        // R9: mode disabled, write and read are ignored
        epp_mode = 1'b0;
        ca = n_astb; cd = n_dstb;
        access(1'b1, 3'd4, 8'hEE, rv, rh);
        check("R9 no strobe", n_astb + n_dstb, ca + cd);
        check("R9 bus unchanged", pd_out, 8'hC3);
        access(1'b0, 3'd3, 8'h00, rv, rh);
        check("R9 read zero", rv, 8'h00);
        epp_mode = 1'b1;

        // R7 and R8: ready stuck high, trailing-edge byte held, timeout length
        mute = 1'b1;
        @(negedge clk); n_wait = 1'b1;
        ca = n_astb; cd = n_dstb;
        host_addr = 3'd5; host_wdata = 8'hA1; host_wr = 1'b1;
        @(negedge clk); host_wdata = 8'hB2;
        @(negedge clk); host_wr = 1'b0; host_wdata = 8'hC3;
        @(negedge clk);
        check("R7 trailing byte held", pd_out, 8'hB2);
        check("R7 bus driven", {pd_oe, n_write}, 2'b10);
        bcnt = 3;
        for (int g = 0; g < 100 && host_busy; g++) begin @(negedge clk); if (host_busy) bcnt++; end
        check("R8 busy length", bcnt, TMO);
        check("R8 no strobe", n_astb + n_dstb, ca + cd);

        // R8: ready stuck low, strobe never acknowledged
        n_wait = 1'b0;
        repeat (2) @(negedge clk);
        host_addr = 3'd3; host_rd = 1'b1;
        bcnt = 0;
        @(negedge clk);
        for (int g = 0; g < 100 && host_busy; g++) begin bcnt++; @(negedge clk); end
        check("R8 busy length low", bcnt, TMO);
        check("R8 strobes released", {n_addrstb, n_datastb}, 2'b11);
        host_rd = 1'b0;
        mute = 1'b0;
        repeat (3) @(negedge clk);

        // R8: recovers for a new access; R6 normal handshake
        ca = n_astb;
        access(1'b1, 3'd3, 8'h6D, rv, rh);
        check("R8 recovery", cap_addr, 8'h6D);
        check("R6 handshake strobe", n_astb - ca, 1);

        // R12 spot check at idle
        check("R12 idle strobes", {n_addrstb, n_datastb}, 2'b11);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule